// File: doc/BRIEF.md
# Metadata-Tagging Load/Store Formatter

This block converts between untagged memory data and a tagged internal operand format. A load request reads one memory line, extracts the addressed element, zero-extends it into the low bytes of the operand and attaches metadata: the requested width code, a vector flag, and cleared error, missing-value and floating-point flag bits. A load that cannot produce a valid value does not trap. It returns an operand with its error (NaR) bit set.

A store request takes a tagged operand and sizes the memory write from the operand's own width code. It places the element in its byte lanes and drives matching byte enables. The metadata is checked before the write is committed. An operand marked as an error raises a fault. An operand marked as missing (None) is dropped silently. A store that commits ORs the floating-point flags it carries into a sticky status register. Only a dedicated write port can clear that register.

Requests are accepted one per cycle. The memory read is combinational, and load results, write strobes, faults and status updates appear one clock after the request.

Top module: `tagged_ls_formatter`

## Requirements
- R1: A load accepted in cycle N gives ld_valid_o=1 in cycle N+1 with metadata {fp flags=0, none=0, nar=bad, vec=req_vector_i, width=req_width_i}. The metadata bit layout is [2:0] width code, [3] vector, [4] NaR, [5] None, [10:6] floating-point flags.
- R2: On a clean load, ld_data_o bytes 0..n-1 are memory line bytes off..off+n-1. Here off is addr[3:0] and n is 2^width code. All higher bytes are zero.
- R3: A store that commits drives mem_we_o=1 one cycle later. mem_be_o has exactly n contiguous bits starting at bit off. mem_wdata_o carries operand bytes 0..n-1 in lanes off..off+n-1 and zero in the other lanes. mem_waddr_o is the line address with the low 4 bits zero.
- R4: A store whose operand has NaR=1 and None=0 gives fault_o=1 with fault_code_o=1. It does not write and leaves the status register unchanged. NaR takes priority over every other fault.
- R5: A store whose operand has None=1 gives no write, no fault and no status change, whatever its other metadata bits hold.
- R6: A store that commits ORs its floating-point flags into fps_o. A store never clears a bit of fps_o.
- R7: Width codes 5..7 are illegal. A store with such a code faults with code 2 and does not write. A load with such a code returns NaR.
- R8: An address whose offset is not a multiple of n makes a store fault with code 3, without writing. It makes a load return NaR.
- R9: A load from address 0, or a load with mem_rerr_i=1, returns NaR with all data bytes zero. No fault is raised by any load.
- R10: fps_we_i loads fps_o with fps_wdata_i on the next edge. It takes priority over a store that commits in the same cycle.
- R11: After reset, all registered outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | ADDR_W | Byte address |
| req_width_i | input | 3 | Load width code |
| req_vector_i | input | 1 | Load vector flag |
| st_data_i | input | 8*LINE_B | Store operand data |
| st_meta_i | input | 11 | Store operand metadata |
| mem_rd_o | output | 1 | Memory read strobe (combinational) |
| mem_raddr_o | output | ADDR_W | Line address for the read |
| mem_rdata_i | input | 8*LINE_B | Line read data, same cycle |
| mem_rerr_i | input | 1 | Read error for the line |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 8*LINE_B | Load operand data |
| ld_meta_o | output | 11 | Load operand metadata |
| mem_we_o | output | 1 | Write strobe |
| mem_waddr_o | output | ADDR_W | Write line address |
| mem_be_o | output | LINE_B | Byte enables |
| mem_wdata_o | output | 8*LINE_B | Write data in byte lanes |
| fault_o | output | 1 | Store fault pulse |
| fault_code_o | output | 2 | 1 NaR, 2 illegal width, 3 misaligned |
| fps_we_i | input | 1 | Status register write |
| fps_wdata_i | input | 5 | Status register write data |
| fps_o | output | 5 | Floating-point status register |

## Verification
The bench sweeps every width code against every line offset, for both loads and stores. A design with an off-by-one in the byte mask, or one that ignores the offset shift, would show stray or missing enables and shifted data. Fault priority is probed with operands that carry several faults at once. A design that ranks the checks wrongly would report a width or alignment code where a NaR code is required, or would fault on a None operand instead of dropping it. The status register is driven through sequences of accumulating stores, faulting stores and port writes, some of them in the same cycle. A register that clears on a store, or that lets a store beat the write port, would show the wrong value.

// File: rtl/lsf_pkg.sv
package lsf_pkg;
  typedef struct packed {
    logic [4:0] fpf;
    logic       none;
    logic       nar;
    logic       vec;
    logic [2:0] wcode;
  } meta_t;

  localparam logic [1:0] FLT_OK    = 2'd0;
  localparam logic [1:0] FLT_NAR   = 2'd1;
  localparam logic [1:0] FLT_WIDTH = 2'd2;
  localparam logic [1:0] FLT_ALIGN = 2'd3;
endpackage

// File: rtl/lsf_width_dec.sv
module lsf_width_dec #(
  parameter int LINE_B = 16,
  localparam int OFF_W = $clog2(LINE_B)
) (
  input  logic [2:0]        wcode_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic              legal_o,
  output logic              aligned_o,
  output logic [LINE_B-1:0] mask_o
);
  localparam int MAX_CODE = OFF_W;

  logic [OFF_W:0] nbytes;

  assign legal_o   = (int'(wcode_i) <= MAX_CODE);
  assign nbytes    = legal_o ? ((OFF_W+1)'(1) << wcode_i) : (OFF_W+1)'(1);
  assign aligned_o = ((off_i & OFF_W'(nbytes - 1'b1)) == '0);

  for (genvar i = 0; i < LINE_B; i++) begin : g_mask
    assign mask_o[i] = legal_o && ((OFF_W+1)'(i) < nbytes);
  end
endmodule

// File: rtl/lsf_load_path.sv
module lsf_load_path
  import lsf_pkg::*;
#(
  parameter int LINE_B = 16,
  parameter int ADDR_W = 16,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int DW    = 8 * LINE_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [2:0]        wcode_i,
  input  logic              vec_i,
  input  logic [DW-1:0]     rdata_i,
  input  logic              rerr_i,
  input  logic              legal_i,
  input  logic              aligned_i,
  input  logic [LINE_B-1:0] mask_i,
  output logic              ld_valid_o,
  output logic [DW-1:0]     ld_data_o,
  output meta_t             ld_meta_o
);
  logic [DW-1:0] shifted, data_n;
  logic          bad;
  meta_t         meta_n;

  assign shifted = rdata_i >> {addr_i[OFF_W-1:0], 3'b000};
  // speculable: every load problem turns into NaR, never a trap
  assign bad = !legal_i || !aligned_i || rerr_i || (addr_i == '0);

  for (genvar i = 0; i < LINE_B; i++) begin : g_byte
    assign data_n[8*i +: 8] = (mask_i[i] && !bad) ? shifted[8*i +: 8] : 8'h00;
  end

  always_comb begin
    meta_n       = '0;
    meta_n.nar   = bad;
    meta_n.vec   = vec_i;
    meta_n.wcode = wcode_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_valid_o <= 1'b0;
      ld_data_o  <= '0;
      ld_meta_o  <= '0;
    end else begin
      ld_valid_o <= take_i;
      if (take_i) begin
        ld_data_o <= data_n;
        ld_meta_o <= meta_n;
      end
    end
  end

  a_r9_nar_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_o && ld_meta_o.nar) |-> (ld_data_o == '0));

  a_r1_load_meta_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> (ld_meta_o.fpf == '0 && !ld_meta_o.none));
endmodule

// File: rtl/lsf_store_check.sv
module lsf_store_check
  import lsf_pkg::*;
#(
  parameter int LINE_B = 16,
  parameter int ADDR_W = 16,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int DW    = 8 * LINE_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  meta_t             meta_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              legal_i,
  input  logic              aligned_i,
  input  logic [LINE_B-1:0] mask_i,
  input  logic              fps_we_i,
  input  logic [4:0]        fps_wdata_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [LINE_B-1:0] mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  output logic [4:0]        fps_o
);
  logic [1:0]    fcode;
  logic          active, commit;
  logic [DW-1:0] data_m;

  always_comb begin
    if (meta_i.nar)      fcode = FLT_NAR;
    else if (!legal_i)   fcode = FLT_WIDTH;
    else if (!aligned_i) fcode = FLT_ALIGN;
    else                 fcode = FLT_OK;
  end

  // None is a silent no-op ahead of every check
  assign active = take_i && !meta_i.none;
  assign commit = active && (fcode == FLT_OK);

  for (genvar i = 0; i < LINE_B; i++) begin : g_dm
    assign data_m[8*i +: 8] = mask_i[i] ? data_i[8*i +: 8] : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o     <= 1'b0;
      mem_waddr_o  <= '0;
      mem_be_o     <= '0;
      mem_wdata_o  <= '0;
      fault_o      <= 1'b0;
      fault_code_o <= FLT_OK;
      fps_o        <= '0;
    end else begin
      mem_we_o     <= commit;
      mem_waddr_o  <= commit ? {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}} : '0;
      mem_be_o     <= commit ? (mask_i << addr_i[OFF_W-1:0]) : '0;
      mem_wdata_o  <= commit ? (data_m << {addr_i[OFF_W-1:0], 3'b000}) : '0;
      fault_o      <= active && (fcode != FLT_OK);
      fault_code_o <= active ? fcode : FLT_OK;
      if (fps_we_i)    fps_o <= fps_wdata_i;
      else if (commit) fps_o <= fps_o | meta_i.fpf;
    end
  end

  a_r4_nar_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && meta_i.nar && !meta_i.none) |=> (fault_o && !mem_we_o && fault_code_o == FLT_NAR));

  a_r5_none_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && meta_i.none && !fps_we_i) |=> (!mem_we_o && !fault_o && $stable(fps_o)));

  a_r6_fps_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fps_we_i |=> ((fps_o & $past(fps_o)) == $past(fps_o)));

  a_r3_be_pow2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> ($countones(mem_be_o) inside {1, 2, 4, 8, 16, 32, 64}));

  a_r3_write_excl_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && fault_o));
endmodule

// File: rtl/tagged_ls_formatter.sv
module tagged_ls_formatter
  import lsf_pkg::*;
#(
  parameter int LINE_B = 16,
  parameter int ADDR_W = 16,
  localparam int OFF_W = $clog2(LINE_B),
  localparam int DW    = 8 * LINE_B
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [2:0]        req_width_i,
  input  logic              req_vector_i,
  input  logic [DW-1:0]     st_data_i,
  input  logic [10:0]       st_meta_i,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_raddr_o,
  input  logic [DW-1:0]     mem_rdata_i,
  input  logic              mem_rerr_i,
  output logic              ld_valid_o,
  output logic [DW-1:0]     ld_data_o,
  output logic [10:0]       ld_meta_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_waddr_o,
  output logic [LINE_B-1:0] mem_be_o,
  output logic [DW-1:0]     mem_wdata_o,
  output logic              fault_o,
  output logic [1:0]        fault_code_o,
  input  logic              fps_we_i,
  input  logic [4:0]        fps_wdata_i,
  output logic [4:0]        fps_o
);
  meta_t             st_meta, ld_meta;
  logic [2:0]        wcode;
  logic              legal, aligned, ld_take, st_take;
  logic [LINE_B-1:0] mask;

  assign st_meta     = meta_t'(st_meta_i);
  assign ld_meta_o   = 11'(ld_meta);
  assign ld_take     = req_valid_i && !req_store_i;
  assign st_take     = req_valid_i && req_store_i;
  // stores are sized by the operand tag, loads by the request
  assign wcode       = req_store_i ? st_meta.wcode : req_width_i;
  assign mem_rd_o    = ld_take;
  assign mem_raddr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsf_width_dec #(.LINE_B(LINE_B)) u_dec (
    .wcode_i   (wcode),
    .off_i     (req_addr_i[OFF_W-1:0]),
    .legal_o   (legal),
    .aligned_o (aligned),
    .mask_o    (mask)
  );

  lsf_load_path #(.LINE_B(LINE_B), .ADDR_W(ADDR_W)) u_ld (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (ld_take),
    .addr_i     (req_addr_i),
    .wcode_i    (req_width_i),
    .vec_i      (req_vector_i),
    .rdata_i    (mem_rdata_i),
    .rerr_i     (mem_rerr_i),
    .legal_i    (legal),
    .aligned_i  (aligned),
    .mask_i     (mask),
    .ld_valid_o (ld_valid_o),
    .ld_data_o  (ld_data_o),
    .ld_meta_o  (ld_meta)
  );

  lsf_store_check #(.LINE_B(LINE_B), .ADDR_W(ADDR_W)) u_st (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .take_i       (st_take),
    .meta_i       (st_meta),
    .addr_i       (req_addr_i),
    .data_i       (st_data_i),
    .legal_i      (legal),
    .aligned_i    (aligned),
    .mask_i       (mask),
    .fps_we_i     (fps_we_i),
    .fps_wdata_i  (fps_wdata_i),
    .mem_we_o     (mem_we_o),
    .mem_waddr_o  (mem_waddr_o),
    .mem_be_o     (mem_be_o),
    .mem_wdata_o  (mem_wdata_o),
    .fault_o      (fault_o),
    .fault_code_o (fault_code_o),
    .fps_o        (fps_o)
  );

  a_r9_load_never_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_take |=> !fault_o);

  a_r1_load_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_take |=> ld_valid_o);

  a_r10_fps_port_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fps_we_i |=> (fps_o == $past(fps_wdata_i)));
endmodule

// File: tb/tb_tagged_ls_formatter.sv
`timescale 1ns/1ps
module tb_tagged_ls_formatter;
  localparam int LINE_B = 16;
  localparam int ADDR_W = 16;
  localparam int DW     = 128;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid = 0, req_store = 0, req_vector = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [2:0]        req_width = '0;
  logic [DW-1:0]     st_data = '0;
  logic [10:0]       st_meta = '0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_raddr;
  logic [DW-1:0]     mem_rdata;
  logic              mem_rerr = 0;
  logic              ld_valid;
  logic [DW-1:0]     ld_data;
  logic [10:0]       ld_meta;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [LINE_B-1:0] mem_be;
  logic [DW-1:0]     mem_wdata;
  logic              fault;
  logic [1:0]        fault_code;
  logic              fps_we = 0;
  logic [4:0]        fps_wdata = '0;
  logic [4:0]        fps;

  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  tagged_ls_formatter dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_store_i(req_store),
    .req_addr_i(req_addr), .req_width_i(req_width), .req_vector_i(req_vector),
    .st_data_i(st_data), .st_meta_i(st_meta), .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr),
    .mem_rdata_i(mem_rdata), .mem_rerr_i(mem_rerr), .ld_valid_o(ld_valid),
    .ld_data_o(ld_data), .ld_meta_o(ld_meta), .mem_we_o(mem_we), .mem_waddr_o(mem_waddr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .fault_o(fault), .fault_code_o(fault_code),
    .fps_we_i(fps_we), .fps_wdata_i(fps_wdata), .fps_o(fps)
  );

  function automatic logic [7:0] mbyte(logic [15:0] a);
    return 8'((a * 7) + 1);
  endfunction

  always_comb
    for (int k = 0; k < LINE_B; k++)
      mem_rdata[8*k +: 8] = mbyte({mem_raddr[15:4], 4'(k)});

  function automatic logic [10:0] mk_meta(logic [4:0] f, logic none, logic nar, logic vec, logic [2:0] w);
    return {f, none, nar, vec, w};
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_load(logic [15:0] a, logic [2:0] w, logic v, logic e);
    req_valid = 1; req_store = 0; req_addr = a; req_width = w; req_vector = v; mem_rerr = e;
    step();
    req_valid = 0; mem_rerr = 0;
  endtask

  task automatic do_store(logic [15:0] a, logic [10:0] m, logic [DW-1:0] d);
    req_valid = 1; req_store = 1; req_addr = a; st_meta = m; st_data = d;
    step();
    req_valid = 0; req_store = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  localparam logic [DW-1:0] SDATA = 128'h0123456789abcdeffedcba9876543210;

  initial begin
    #7;
    // R11 reset state
    chk("R11 ld_valid", DW'(ld_valid), 0);
    chk("R11 mem_we/be", DW'({mem_we, mem_be}), 0);
    chk("R11 fault/fps", DW'({fault, fault_code, fps}), 0);
    @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1 R2 R7 R8: load sweep over width code and offset
    for (int w = 0; w < 8; w++) begin
      for (int off = 0; off < 16; off++) begin
        logic [15:0] a;
        int nb;
        logic bad;
        logic [DW-1:0] exp;
        a   = 16'((w + 1) * 64 + off);
        nb  = (w <= 4) ? (1 << w) : 1;
        bad = (w > 4) || ((off % nb) != 0);
        exp = '0;
        if (!bad)
          for (int i = 0; i < nb; i++) exp[8*i +: 8] = mbyte(a + 16'(i));
        do_load(a, 3'(w), off[0], 1'b0);
        chk("R1 load meta", DW'({ld_valid, ld_meta}),
            DW'({1'b1, mk_meta(5'b0, 1'b0, bad, off[0], 3'(w))}));
        chk(bad ? "R8/R7 load data" : "R2 load data", ld_data, exp);
        chk("R9 no load fault", DW'(fault), 0);
      end
    end

    // R9 address zero and read error
    do_load(16'h0000, 3'd0, 1'b0, 1'b0);
    chk("R9 addr0 nar", DW'({ld_meta, ld_data == '0}), DW'({mk_meta(0, 0, 1, 0, 0), 1'b1}));
    do_load(16'h0208, 3'd3, 1'b1, 1'b1);
    chk("R9 rerr nar", DW'({ld_meta, ld_data == '0}), DW'({mk_meta(0, 0, 1, 1, 3), 1'b1}));
    chk("R9 rerr no fault", DW'(fault), 0);

    // R3 R7 R8: store sweep
    for (int w = 0; w < 8; w++) begin
      for (int off = 0; off < 16; off++) begin
        logic [15:0] a;
        int nb;
        logic [1:0] ec;
        logic [LINE_B-1:0] ebe;
        logic [DW-1:0] ed;
        a   = 16'h1230 + 16'(off);
        nb  = (w <= 4) ? (1 << w) : 1;
        ec  = (w > 4) ? 2'd2 : (((off % nb) != 0) ? 2'd3 : 2'd0);
        ebe = '0;
        ed  = '0;
        if (ec == 0)
          for (int i = 0; i < nb; i++) begin
            ebe[off + i] = 1'b1;
            ed[8*(off + i) +: 8] = SDATA[8*i +: 8];
          end
        do_store(a, mk_meta(5'b0, 0, 0, 0, 3'(w)), SDATA);
        chk(ec == 0 ? "R3 we/be" : (ec == 2 ? "R7 store fault" : "R8 store fault"),
            DW'({mem_we, mem_be, fault, fault_code}),
            DW'({ec == 0, ebe, ec != 0, ec}));
        chk("R3 wdata", mem_wdata, ed);
        if (ec == 0) chk("R3 waddr", DW'(mem_waddr), DW'(16'h1230));
      end
    end

    // R6 accumulate
    do_store(16'h0040, mk_meta(5'b00101, 0, 0, 0, 3'd2), SDATA);
    chk("R6 fps or1", DW'(fps), DW'(5'b00101));
    do_store(16'h0050, mk_meta(5'b01000, 0, 0, 0, 3'd0), SDATA);
    chk("R6 fps or2", DW'(fps), DW'(5'b01101));
    do_store(16'h0060, mk_meta(5'b00000, 0, 0, 0, 3'd1), SDATA);
    chk("R6 fps no clear", DW'(fps), DW'(5'b01101));

    // R4 NaR: faults, no write, fps held; priority over width/align
    do_store(16'h0040, mk_meta(5'b10000, 0, 1, 0, 3'd2), SDATA);
    chk("R4 nar fault", DW'({mem_we, fault, fault_code, fps}), DW'({1'b0, 1'b1, 2'd1, 5'b01101}));
    do_store(16'h0043, mk_meta(5'b10000, 0, 1, 0, 3'd7), SDATA);
    chk("R4 nar priority", DW'({mem_we, fault, fault_code}), DW'({1'b0, 1'b1, 2'd1}));
    do_store(16'h0041, mk_meta(5'b10000, 0, 0, 0, 3'd1), SDATA);
    chk("R8 misalign no fps", DW'({fault_code, fps}), DW'({2'd3, 5'b01101}));

    // R5 None silent even with other bits set
    do_store(16'h0043, mk_meta(5'b10010, 1, 1, 0, 3'd6), SDATA);
    chk("R5 none silent", DW'({mem_we, fault, fault_code, fps}), DW'({1'b0, 1'b0, 2'd0, 5'b01101}));
    do_store(16'h0040, mk_meta(5'b10000, 1, 0, 0, 3'd2), SDATA);
    chk("R5 none no fps", DW'({mem_we, fps}), DW'({1'b0, 5'b01101}));

    // R10 port write, and wins over a committing store
    fps_we = 1; fps_wdata = 5'b00000;
    step();
    fps_we = 0;
    chk("R10 port clear", DW'(fps), 0);
    fps_we = 1; fps_wdata = 5'b00010;
    do_store(16'h0040, mk_meta(5'b11100, 0, 0, 0, 3'd2), SDATA);
    fps_we = 0;
    chk("R10 port wins", DW'({mem_we, fps}), DW'({1'b1, 5'b00010}));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule